// File: doc/BRIEF.md
# Triggered Microcode Trace Buffer

This block keeps a rolling record of what a microcoded processor executed. While it is armed it stores one entry on every clock: the 16-bit micro program counter in the upper bits and eight probe bits, which can be wired to any signal of interest, in the lower bits. The entries go into a 256-entry circular RAM. When the write pointer wraps, each new entry replaces the oldest one.

A comparator watches the micro program counter for an address that the host programs. The first hit after arming starts a post-trigger countdown. When the countdown ends, recording stops, so the RAM holds the history on both sides of the event. Every hit also produces a registered pulse on a sync pin, which can trigger an oscilloscope. When capture stops, the block reports the position of the oldest entry. The host can then read the trace in time order through a read port with one cycle of latency.

Top module: `tbuf_top`

## Requirements
- R1: While `rst_n` is low, `rec_o`, `trig_o`, `stopped_o` and `sync_o` are 0 and `stop_ptr_o` is 0.
- R2: A cycle with `arm_i` high latches `match_addr_i` and `post_cnt_i`. On the next cycle `rec_o` is 1 and both `trig_o` and `stopped_o` are 0. This holds even if the buffer was already recording.
- R3: In each cycle where `rec_o` is 1, the entry `{upc_i, probe_i}` is written at the write pointer, then the pointer advances by one modulo 256. The program counter occupies bits 23:8 and the probe bits occupy bits 7:0.
- R4: The first recording cycle where `upc_i` equals the latched match address writes its entry and triggers. Exactly N more entries are then written, where N is the latched post count (0 to 255), and `rec_o` falls to 0 while `stopped_o` rises to 1. With N = 0, the matching entry is the last one written.
- R5: While `stopped_o` is 1, `stop_ptr_o` holds the address that follows the last written entry. This is the oldest entry in the trace.
- R6: `sync_o` is 1 in the cycle after `upc_i` equals the latched match address. This holds whether or not the buffer is recording.
- R7: Once triggered (`trig_o` = 1), a further match does not restart the post-trigger countdown.
- R8: Re-arming does not clear or alter the RAM. Entries that are not overwritten after the re-arm keep their earlier values.
- R9: `rd_data_o` shows the RAM entry at the address `rd_addr_i` held in the previous cycle.
- R10: While `rec_o` is 0, no entry is written and the write pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one microinstruction per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| upc_i | input | 16 | Micro program counter of the current cycle |
| probe_i | input | 8 | User-attached probe signals |
| arm_i | input | 1 | Arm pulse: latch settings and start recording |
| match_addr_i | input | 16 | Trigger address, latched on arm |
| post_cnt_i | input | 8 | Entries to record after the trigger, latched on arm |
| rd_addr_i | input | 8 | Host read address |
| rd_data_o | output | 24 | Entry read back, one cycle after the address |
| sync_o | output | 1 | Registered match pulse for scope sync |
| rec_o | output | 1 | Recording is active |
| trig_o | output | 1 | Triggered, post-trigger countdown running |
| stopped_o | output | 1 | Capture finished |
| stop_ptr_o | output | 8 | Oldest entry position after stop |

## Verification
The bench runs a long capture so that the write pointer wraps and the trigger entry lands on address 0. It places a second match during the countdown: a design that restarts the count on that second match stops six entries late. The bench also covers a post count of 0, where an off-by-one design writes one extra entry, and a post count of 255, where a narrow counter would stop early. It re-arms mid-run and re-arms after a stop, reading back entries from the earlier capture to find a design that clears the RAM or moves the pointer. Finally, it drives the match address while the buffer is idle and expects a sync pulse; a design that gates sync on recording would miss it.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;

    // Capture phase of the trace controller
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // never armed since reset
        ST_RUN  = 2'd1,   // recording, waiting for the match
        ST_POST = 2'd2,   // recording, post-trigger countdown
        ST_DONE = 2'd3    // capture frozen
    } tbuf_state_e;

endpackage

// File: rtl/tbuf_cmp.sv
module tbuf_cmp #(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] upc_i,
    input  logic [PC_W-1:0] match_i,
    output logic            hit_o,
    output logic            sync_o
);

    logic sync_d, sync_q;

    always_comb begin
        hit_o  = (upc_i == match_i);
        sync_d = hit_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q;

endmodule

// File: rtl/tbuf_ram.sv
module tbuf_ram #(
    parameter int AW = 8,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rdata_q;

    // Read returns the contents before a same-edge write
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
        rdata_q <= mem_q[raddr_i];
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/tbuf_ctrl.sv
module tbuf_ctrl
    import tbuf_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int PTR_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [PC_W-1:0]  match_addr_i,
    input  logic [CNT_W-1:0] post_cnt_i,
    input  logic             hit_i,
    output logic [PC_W-1:0]  match_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_ptr_o,
    output logic             rec_o,
    output logic             trig_o,
    output logic             stopped_o,
    output logic [PTR_W-1:0] stop_ptr_o
);

    typedef struct packed {
        tbuf_state_e      st;
        logic [PC_W-1:0]  match;
        logic [CNT_W-1:0] post;
        logic [CNT_W-1:0] remain;
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] stop_ptr;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        st:       ST_IDLE,
        match:    '0,
        post:     '0,
        remain:   '0,
        wr_ptr:   '0,
        stop_ptr: '0
    };

    ctrl_t s_d, s_q;
    logic  recording;
    logic  finish;

    always_comb begin
        s_d       = s_q;
        finish    = 1'b0;
        recording = (s_q.st == ST_RUN) || (s_q.st == ST_POST);

        if (recording) begin
            s_d.wr_ptr = s_q.wr_ptr + PTR_W'(1);
            if (s_q.st == ST_RUN) begin
                if (hit_i) begin
                    if (s_q.post == '0) begin
                        finish = 1'b1;
                    end else begin
                        s_d.st     = ST_POST;
                        s_d.remain = s_q.post;
                    end
                end
            end else begin
                if (s_q.remain == CNT_W'(1)) begin
                    finish = 1'b1;
                end else begin
                    s_d.remain = s_q.remain - CNT_W'(1);
                end
            end
            if (finish) begin
                s_d.st       = ST_DONE;
                s_d.stop_ptr = s_q.wr_ptr + PTR_W'(1);
            end
        end

        // Arming wins over a stop in the same cycle
        if (arm_i) begin
            s_d.st     = ST_RUN;
            s_d.match  = match_addr_i;
            s_d.post   = post_cnt_i;
            s_d.remain = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= CTRL_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign match_o    = s_q.match;
    assign wr_en_o    = recording;
    assign wr_ptr_o   = s_q.wr_ptr;
    assign rec_o      = recording;
    assign trig_o     = (s_q.st == ST_POST);
    assign stopped_o  = (s_q.st == ST_DONE);
    assign stop_ptr_o = s_q.stop_ptr;

endmodule

// File: rtl/tbuf_top.sv
module tbuf_top #(
    parameter int PC_W    = 16,
    parameter int PROBE_W = 8,
    parameter int ADDR_W  = 8,
    parameter int CNT_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PC_W-1:0]           upc_i,
    input  logic [PROBE_W-1:0]        probe_i,
    input  logic                      arm_i,
    input  logic [PC_W-1:0]           match_addr_i,
    input  logic [CNT_W-1:0]          post_cnt_i,
    input  logic [ADDR_W-1:0]         rd_addr_i,
    output logic [PC_W+PROBE_W-1:0]   rd_data_o,
    output logic                      sync_o,
    output logic                      rec_o,
    output logic                      trig_o,
    output logic                      stopped_o,
    output logic [ADDR_W-1:0]         stop_ptr_o
);

    localparam int ENTRY_W = PC_W + PROBE_W;

    logic [PC_W-1:0]    match_w;
    logic               hit_w;
    logic               wr_en_w;
    logic [ADDR_W-1:0]  wr_ptr_w;
    logic [ENTRY_W-1:0] entry_w;

    assign entry_w = {upc_i, probe_i};

    tbuf_cmp #(
        .PC_W (PC_W)
    ) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .upc_i   (upc_i),
        .match_i (match_w),
        .hit_o   (hit_w),
        .sync_o  (sync_o)
    );

    tbuf_ctrl #(
        .PC_W  (PC_W),
        .PTR_W (ADDR_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_i        (arm_i),
        .match_addr_i (match_addr_i),
        .post_cnt_i   (post_cnt_i),
        .hit_i        (hit_w),
        .match_o      (match_w),
        .wr_en_o      (wr_en_w),
        .wr_ptr_o     (wr_ptr_w),
        .rec_o        (rec_o),
        .trig_o       (trig_o),
        .stopped_o    (stopped_o),
        .stop_ptr_o   (stop_ptr_o)
    );

    tbuf_ram #(
        .AW (ADDR_W),
        .DW (ENTRY_W)
    ) u_ram (
        .clk     (clk),
        .we_i    (wr_en_w),
        .waddr_i (wr_ptr_w),
        .wdata_i (entry_w),
        .raddr_i (rd_addr_i),
        .rdata_o (rd_data_o)
    );

endmodule

// File: rtl/tbuf_chk.sv
module tbuf_chk #(
    parameter int PC_W   = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm_i,
    input logic [PC_W-1:0]   upc_i,
    input logic [PC_W-1:0]   match_q,
    input logic              sync_o,
    input logic              rec_o,
    input logic              trig_o,
    input logic              stopped_o,
    input logic [ADDR_W-1:0] wr_ptr,
    input logic [ADDR_W-1:0] stop_ptr_o
);

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!rec_o && !trig_o && !stopped_o && !sync_o));

    p_arm_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (rec_o && !trig_o && !stopped_o));

    p_stop_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rec_o) |-> stopped_o);

    p_oldest_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stopped_o |-> (stop_ptr_o == wr_ptr));

    p_sync_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> ($past(upc_i) == $past(match_q)));

    p_no_retrigger_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && !arm_i) |=> (trig_o || stopped_o));

    p_idle_ptr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_o |=> $stable(wr_ptr));

    p_flags_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rec_o, stopped_o}));

endmodule

bind tbuf_top tbuf_chk #(
    .PC_W   (PC_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (arm_i),
    .upc_i      (upc_i),
    .match_q    (match_w),
    .sync_o     (sync_o),
    .rec_o      (rec_o),
    .trig_o     (trig_o),
    .stopped_o  (stopped_o),
    .wr_ptr     (wr_ptr_w),
    .stop_ptr_o (stop_ptr_o)
);

// File: tb/tbuf_top_tb_top.sv
module tbuf_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] upc_i = '0;
    logic [7:0]  probe_i = '0;
    logic        arm_i = 1'b0;
    logic [15:0] match_addr_i = '0;
    logic [7:0]  post_cnt_i = '0;
    logic [7:0]  rd_addr_i = '0;
    logic [23:0] rd_data_o;
    logic        sync_o, rec_o, trig_o, stopped_o;
    logic [7:0]  stop_ptr_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    // Reference model state
    bit [23:0] exp_mem [256];
    bit [7:0]  m_ptr = 0;
    bit        m_rec = 0, m_trig = 0, m_stopped = 0, m_sync = 0;
    bit [15:0] m_match = 0;
    bit [7:0]  m_post = 0, m_rem = 0, m_stop_ptr = 0;

    // Scoreboard queues for read-back
    logic [23:0] exp_q[$];
    int          tag_q[$];
    string       req_q[$];

    tbuf_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .upc_i        (upc_i),
        .probe_i      (probe_i),
        .arm_i        (arm_i),
        .match_addr_i (match_addr_i),
        .post_cnt_i   (post_cnt_i),
        .rd_addr_i    (rd_addr_i),
        .rd_data_o    (rd_data_o),
        .sync_o       (sync_o),
        .rec_o        (rec_o),
        .trig_o       (trig_o),
        .stopped_o    (stopped_o),
        .stop_ptr_o   (stop_ptr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Monitor: compares the read data one cycle after each request (R9)
    always @(negedge clk) begin
        if (tag_q.size() > 0 && tag_q[0] < cyc) begin
            chk(rd_data_o === exp_q[0], req_q[0], {8'h0, rd_data_o}, {8'h0, exp_q[0]});
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
            void'(req_q.pop_front());
        end
    end

    // One cycle of stimulus; the model follows R2..R7 and R10
    task automatic step(input logic [15:0] pc, input logic [7:0] pr,
                        input bit a = 0, input logic [15:0] mt = 16'h0, input logic [7:0] pn = 8'h0);
        bit hit;
        bit fin;
        upc_i        = pc;
        probe_i      = pr;
        arm_i        = a;
        match_addr_i = mt;
        post_cnt_i   = pn;
        hit = (pc == m_match);
        fin = 0;
        if (m_rec) begin
            exp_mem[m_ptr] = {pc, pr};
            m_ptr = m_ptr + 8'd1;
            if (!m_trig) begin
                if (hit) begin
                    if (m_post == 0) fin = 1;
                    else begin m_trig = 1; m_rem = m_post; end
                end
            end else begin
                if (m_rem == 1) fin = 1;
                else m_rem = m_rem - 8'd1;
            end
            if (fin) begin
                m_rec = 0; m_trig = 0; m_stopped = 1; m_stop_ptr = m_ptr;
            end
        end
        if (a) begin
            m_rec = 1; m_trig = 0; m_stopped = 0; m_match = mt; m_post = pn;
        end
        m_sync = hit;
        @(posedge clk);
        @(negedge clk);
        arm_i = 1'b0;
        chk(rec_o === m_rec, a ? "R2" : "R4", {31'h0, rec_o}, {31'h0, m_rec});
        chk(stopped_o === m_stopped, "R4", {31'h0, stopped_o}, {31'h0, m_stopped});
        chk(trig_o === m_trig, "R7", {31'h0, trig_o}, {31'h0, m_trig});
        chk(sync_o === m_sync, "R6", {31'h0, sync_o}, {31'h0, m_sync});
        if (m_stopped)
            chk(stop_ptr_o === m_stop_ptr, "R5", {24'h0, stop_ptr_o}, {24'h0, m_stop_ptr});
    endtask

    // Driver: queue expected entries and issue read addresses
    task automatic read_range(input logic [7:0] start, input int n, input string req);
        for (int k = 0; k < n; k++) begin
            logic [7:0] ad;
            ad = start + 8'(k);
            rd_addr_i = ad;
            exp_q.push_back(exp_mem[ad]);
            tag_q.push_back(cyc);
            req_q.push_back(req);
            @(posedge clk);
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rec_o === 1'b0, "R1", {31'h0, rec_o}, 32'h0);
        chk(stopped_o === 1'b0, "R1", {31'h0, stopped_o}, 32'h0);
        chk(sync_o === 1'b0, "R1", {31'h0, sync_o}, 32'h0);
        chk(trig_o === 1'b0, "R1", {31'h0, trig_o}, 32'h0);
        chk(stop_ptr_o === 8'h0, "R1", {24'h0, stop_ptr_o}, 32'h0);
        rst_n = 1'b1;
        step(16'hFFFF, 8'h00);

        // Long capture: wrap, trigger at address 0, second match during countdown (R3, R4, R7)
        step(16'hFFFF, 8'h00, 1, 16'h0200, 8'd20);
        for (int i = 0; i < 300; i++)
            step((i == 262) ? 16'h0200 : 16'h0100 + 16'(i), 8'(i) ^ 8'hA5);
        // R6: sync while idle
        step(16'h0200, 8'h11);
        step(16'h0201, 8'h12);
        // R10: idle cycles wrote nothing; R3 oldest-first read-back
        chk(stop_ptr_o === 8'd21, "R10", {24'h0, stop_ptr_o}, 32'd21);
        read_range(stop_ptr_o, 256, "R3/R9/R10");

        // Post count 0; older entries must survive re-arm (R4, R8)
        step(16'hFFFF, 8'h00, 1, 16'h0ABC, 8'd0);
        for (int i = 0; i < 10; i++) step(16'h3000 + 16'(i), 8'(i));
        step(16'h0ABC, 8'h77);
        for (int i = 0; i < 5; i++) step(16'h3100 + 16'(i), 8'(i));
        chk(stop_ptr_o === 8'd32, "R4", {24'h0, stop_ptr_o}, 32'd32);
        read_range(8'd0, 64, "R8");

        // Re-arm mid-run, then post count 255 (R2, R4)
        step(16'hFFFF, 8'h00, 1, 16'h7777, 8'd255);
        for (int i = 0; i < 50; i++) step(16'h5000 + 16'(i), 8'(i) ^ 8'h3C);
        step(16'h5000 + 16'd50, 8'h3C, 1, 16'h5100, 8'd255);
        for (int i = 51; i < 530; i++) step(16'h5000 + 16'(i), 8'(i) ^ 8'h3C);
        read_range(stop_ptr_o, 256, "R3");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule